// File: doc/BRIEF.md
# UART Flow Controller

This block decides, for a UART, when the local transmitter may start a byte and when the far-end sender should be asked to pause. It combines three mechanisms.

The first is a modem-line gate on the transmitter, driven by the clear-to-send input. The second is a request-to-send output that follows the receive FIFO fill level against a pair of programmable thresholds. The third is in-band software flow control: it compares each received character against four programmable control words.

The serializer, the deserializer and the FIFOs sit outside this block. The transmitter reports whether a byte is in flight and strobes the middle of its final stop bit. The receive path presents each character with a valid strobe and its FIFO level. It then uses the drop flag returned in the same cycle to decide whether to store that character.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, the transmitter is permitted (`tx_permit`=1), `rts_n`=0 (active), and `xoff_evt`, `spec_evt` and the software pause are all 0.
- R2: With `cfg_cts_en`=0, the `cts_n` input has no effect: `tx_permit` is 1 whenever no software pause is in force, in the same cycle the enable clears.
- R3: While `tx_busy`=1, a change on `cts_n` alters `tx_permit` only at a `tx_stop_mid` strobe. The level seen there, after `SYNC_STAGES` register stages, decides the next byte.
- R4: While `tx_busy`=0 and `cfg_cts_en`=1, `tx_permit` follows `cts_n` (0 = clear to send) with a latency of `SYNC_STAGES`+1 clocks.
- R5: With `cfg_rts_en`=1, `rts_n` goes to 1 one clock after `rx_level` >= `cfg_halt_lvl`. The halt condition wins when both thresholds are met.
- R6: With `cfg_rts_en`=1, `rts_n` returns to 0 one clock after `rx_level` <= `cfg_resume_lvl` while below the halt level. Between the thresholds, it keeps its value.
- R7: With `cfg_rts_en`=0, `rts_n` is 0 one clock later, whatever the level.
- R8: In single-word modes (`cfg_sw_mode` 1 = word set one, 2 = word set two), a received Xoff word is dropped and pauses the transmitter. It also gives a one-clock `xoff_evt` in the clock after the character. If the Xon and Xoff words are equal, Xoff wins.
- R9: In single-word modes, a received Xon word is dropped and ends the pause. Any other character is not dropped and leaves the pause unchanged.
- R10: In sequence mode (`cfg_sw_mode`=3), the word-one control character is dropped and arms the sequence. A word-two character that follows it completes the Xoff (pause plus event) or the Xon (resume). Any other character disarms the sequence and is not dropped.
- R11: With `cfg_xon_any`=1 and the transmitter paused, any received character resumes it, is not dropped, and disarms the sequence. A word-one Xon taken this way therefore leaves the following word-two Xon as plain data.
- R12: With `cfg_spec_en`=1, a received character equal to the word-two Xoff gives a one-clock `spec_evt` in the next clock, in every mode, including mode 0.
- R13: While a software pause is in force, `tx_permit` is 0. With `cfg_sw_mode`=0, the pause is cleared one clock later and no character is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cfg_rts_en | input | 1 | Enable threshold-driven request-to-send |
| cfg_sw_mode | input | 2 | 0 off, 1 word set one, 2 word set two, 3 sequence |
| cfg_xon_any | input | 1 | Any character resumes a paused transmitter |
| cfg_spec_en | input | 1 | Special-character event on word-two Xoff |
| cfg_xon1 | input | CHAR_W | Xon word one |
| cfg_xon2 | input | CHAR_W | Xon word two |
| cfg_xoff1 | input | CHAR_W | Xoff word one |
| cfg_xoff2 | input | CHAR_W | Xoff word two |
| cfg_halt_lvl | input | LVL_W | FIFO level at which RTS halts the sender |
| cfg_resume_lvl | input | LVL_W | FIFO level at or below which RTS resumes |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_busy | input | 1 | A byte is being serialized |
| tx_stop_mid | input | 1 | Strobe at the middle of the last stop bit |
| rx_char | input | CHAR_W | Received character |
| rx_valid | input | 1 | `rx_char` is valid this clock |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_permit | output | 1 | Transmitter may start the next byte |
| rts_n | output | 1 | Request-to-send pin, active low |
| rx_drop | output | 1 | Do not store the present character |
| xoff_evt | output | 1 | One-clock pulse on a recognised Xoff |
| spec_evt | output | 1 | One-clock pulse on a special character |

## Verification
The embedded properties watch every cycle for several invariants:
- the sampled clear-to-send state holds still through a byte unless the stop-bit strobe arrives;
- RTS obeys both thresholds and the disable;
- a drop or event never appears without a received character;
- a software pause always withholds the permit.

Only the bench scenarios can show the rest. These cover the exact synchronizer latency, the full level ramps against several threshold pairs (including equal and inverted ones), character sweeps through every code in each single-word mode, and the two-word sequences. They also cover the Xon-Any case, in which a word-one Xon resumes and lets the word-two Xon through as data.

// File: rtl/flow_pkg.sv
package flow_pkg;
   typedef enum logic [1:0] {
      SW_OFF   = 2'd0,
      SW_PAIR1 = 2'd1,
      SW_PAIR2 = 2'd2,
      SW_SEQ   = 2'd3
   } sw_mode_e;
endpackage

// File: rtl/flow_cts_gate.sv
module flow_cts_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_cts_en,
   input  logic cts_n,
   input  logic tx_busy,
   input  logic tx_stop_mid,
   output logic hw_ok
);
   logic cts_s;
   logic cts_ok_q;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("flow_cts_gate: SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cts_s = cts_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= (sr << 1) | SYNC_STAGES'(cts_n);
         end
         assign cts_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   // Decision point: idle line tracks continuously, a byte in flight only at mid stop bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cts_ok_q <= 1'b1;
      else if (!tx_busy || tx_stop_mid)  cts_ok_q <= !cts_s;
   end

   assign hw_ok = !cfg_cts_en || cts_ok_q;

   // R3: sampled state frozen through a byte unless the stop-bit strobe fires
   p_hold_midbyte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && !tx_stop_mid) |=> $stable(cts_ok_q));
endmodule

// File: rtl/flow_rts_thresh.sv
module flow_rts_thresh #(
   parameter int LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_rts_en,
   input  logic [LVL_W-1:0] cfg_halt_lvl,
   input  logic [LVL_W-1:0] cfg_resume_lvl,
   input  logic [LVL_W-1:0] rx_level,
   output logic             rts_n
);
   logic halted_q;
   logic at_halt;
   logic at_resume;

   generate
      if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl
         $error("flow_rts_thresh: LVL_W must be 2..16");
      end
   endgenerate

   assign at_halt   = (rx_level >= cfg_halt_lvl);
   assign at_resume = (rx_level <= cfg_resume_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           halted_q <= 1'b0;
      else if (!cfg_rts_en) halted_q <= 1'b0;
      else if (at_halt)     halted_q <= 1'b1;
      else if (at_resume)   halted_q <= 1'b0;
   end

   assign rts_n = halted_q;

   p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rts_en && rx_level >= cfg_halt_lvl) |=> rts_n);
   p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rts_en && rx_level < cfg_halt_lvl && rx_level <= cfg_resume_lvl) |=> !rts_n);
   p_off_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rts_en |=> !rts_n);
endmodule

// File: rtl/flow_xonxoff.sv
module flow_xonxoff
   import flow_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sw_mode_e          mode,
   input  logic              cfg_xon_any,
   input  logic              cfg_spec_en,
   input  logic [CHAR_W-1:0] cfg_xon1,
   input  logic [CHAR_W-1:0] cfg_xon2,
   input  logic [CHAR_W-1:0] cfg_xoff1,
   input  logic [CHAR_W-1:0] cfg_xoff2,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              rx_valid,
   output logic              rx_drop,
   output logic              sw_hold,
   output logic              xoff_evt,
   output logic              spec_evt
);
   logic hold_q, arm_on_q, arm_off_q;
   logic nxt_hold, nxt_arm_on, nxt_arm_off, hit_off;
   logic [CHAR_W-1:0] on_w, off_w;

   generate
      if (CHAR_W < 5 || CHAR_W > 9) begin : g_bad_char
         $error("flow_xonxoff: CHAR_W must be 5..9");
      end
   endgenerate

   assign on_w  = (mode == SW_PAIR2) ? cfg_xon2  : cfg_xon1;
   assign off_w = (mode == SW_PAIR2) ? cfg_xoff2 : cfg_xoff1;

   always_comb begin
      nxt_hold    = hold_q;
      nxt_arm_on  = arm_on_q;
      nxt_arm_off = arm_off_q;
      rx_drop     = 1'b0;
      hit_off     = 1'b0;
      if (mode == SW_OFF) begin
         nxt_hold    = 1'b0;
         nxt_arm_on  = 1'b0;
         nxt_arm_off = 1'b0;
      end else if (rx_valid) begin
         if (cfg_xon_any && hold_q) begin
            nxt_hold    = 1'b0;
            nxt_arm_on  = 1'b0;
            nxt_arm_off = 1'b0;
         end else if (mode == SW_SEQ) begin
            if (arm_off_q && rx_char == cfg_xoff2) begin
               rx_drop = 1'b1; hit_off = 1'b1; nxt_hold = 1'b1;
               nxt_arm_on = 1'b0; nxt_arm_off = 1'b0;
            end else if (arm_on_q && rx_char == cfg_xon2) begin
               rx_drop = 1'b1; nxt_hold = 1'b0;
               nxt_arm_on = 1'b0; nxt_arm_off = 1'b0;
            end else if (rx_char == cfg_xoff1) begin
               rx_drop = 1'b1; nxt_arm_off = 1'b1; nxt_arm_on = 1'b0;
            end else if (rx_char == cfg_xon1) begin
               rx_drop = 1'b1; nxt_arm_on = 1'b1; nxt_arm_off = 1'b0;
            end else begin
               nxt_arm_on = 1'b0; nxt_arm_off = 1'b0;
            end
         end else begin
            if (rx_char == off_w) begin
               rx_drop = 1'b1; hit_off = 1'b1; nxt_hold = 1'b1;
            end else if (rx_char == on_w) begin
               rx_drop = 1'b1; nxt_hold = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= 1'b0;
         arm_on_q  <= 1'b0;
         arm_off_q <= 1'b0;
         xoff_evt  <= 1'b0;
         spec_evt  <= 1'b0;
      end else begin
         hold_q    <= nxt_hold;
         arm_on_q  <= nxt_arm_on;
         arm_off_q <= nxt_arm_off;
         xoff_evt  <= hit_off;
         spec_evt  <= cfg_spec_en && rx_valid && (rx_char == cfg_xoff2);
      end
   end

   assign sw_hold = hold_q;

   p_evt_needs_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_evt || spec_evt) |-> $past(rx_valid));
   p_drop_needs_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_drop |-> rx_valid);
   p_seq_arm_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(arm_on_q && arm_off_q));
   p_off_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SW_OFF) |=> !sw_hold);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
   import flow_pkg::*;
#(
   parameter int CHAR_W      = 8,
   parameter int LVL_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cts_en,
   input  logic              cfg_rts_en,
   input  logic [1:0]        cfg_sw_mode,
   input  logic              cfg_xon_any,
   input  logic              cfg_spec_en,
   input  logic [CHAR_W-1:0] cfg_xon1,
   input  logic [CHAR_W-1:0] cfg_xon2,
   input  logic [CHAR_W-1:0] cfg_xoff1,
   input  logic [CHAR_W-1:0] cfg_xoff2,
   input  logic [LVL_W-1:0]  cfg_halt_lvl,
   input  logic [LVL_W-1:0]  cfg_resume_lvl,
   input  logic              cts_n,
   input  logic              tx_busy,
   input  logic              tx_stop_mid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              rx_valid,
   input  logic [LVL_W-1:0]  rx_level,
   output logic              tx_permit,
   output logic              rts_n,
   output logic              rx_drop,
   output logic              xoff_evt,
   output logic              spec_evt
);
   logic hw_ok;
   logic sw_hold;

   flow_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) i_cts (
      .clk(clk), .rst_n(rst_n), .cfg_cts_en(cfg_cts_en), .cts_n(cts_n),
      .tx_busy(tx_busy), .tx_stop_mid(tx_stop_mid), .hw_ok(hw_ok));

   flow_rts_thresh #(.LVL_W(LVL_W)) i_rts (
      .clk(clk), .rst_n(rst_n), .cfg_rts_en(cfg_rts_en),
      .cfg_halt_lvl(cfg_halt_lvl), .cfg_resume_lvl(cfg_resume_lvl),
      .rx_level(rx_level), .rts_n(rts_n));

   flow_xonxoff #(.CHAR_W(CHAR_W)) i_sw (
      .clk(clk), .rst_n(rst_n), .mode(sw_mode_e'(cfg_sw_mode)),
      .cfg_xon_any(cfg_xon_any), .cfg_spec_en(cfg_spec_en),
      .cfg_xon1(cfg_xon1), .cfg_xon2(cfg_xon2),
      .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
      .rx_char(rx_char), .rx_valid(rx_valid), .rx_drop(rx_drop),
      .sw_hold(sw_hold), .xoff_evt(xoff_evt), .spec_evt(spec_evt));

   assign tx_permit = hw_ok && !sw_hold;

   p_pause_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
      sw_hold |-> !tx_permit);
endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
   localparam int CW = 8;
   localparam int LW = 7;
   localparam int SY = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cts_en = 0, cfg_rts_en = 0, cfg_xon_any = 0, cfg_spec_en = 0;
   logic [1:0] cfg_sw_mode = 2'd0;
   logic [CW-1:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h91, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h93;
   logic [LW-1:0] cfg_halt_lvl = '0, cfg_resume_lvl = '0, rx_level = '0;
   logic cts_n = 1'b0, tx_busy = 1'b0, tx_stop_mid = 1'b0, rx_valid = 1'b0;
   logic [CW-1:0] rx_char = '0;
   logic tx_permit, rts_n, rx_drop, xoff_evt, spec_evt;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   uart_flow_ctrl #(.CHAR_W(CW), .LVL_W(LW), .SYNC_STAGES(SY)) i_uart_flow_ctrl (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   // send one character; check drop in-cycle, then events and permit after the edge
   task automatic send(input logic [7:0] c, input string req, input logic exp_drop,
                       input logic exp_xoff, input logic exp_spec, input logic exp_permit);
      rx_char = c; rx_valid = 1'b1;
      #1 chk({req, " drop"}, rx_drop, exp_drop);
      @(posedge clk); @(negedge clk);
      rx_valid = 1'b0;
      #1;
      chk({req, " xoff_evt"}, xoff_evt, exp_xoff);
      chk({req, " spec_evt"}, spec_evt, exp_spec);
      chk({req, " permit"}, tx_permit, exp_permit);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic hold_m, halt_m;
      logic [7:0] xon_w, xoff_w;
      int lv;
      int pairs_h [4] = '{100, 10, 5, 127};
      int pairs_r [4] = '{20, 10, 9, 0};

      edges(3);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 permit", tx_permit, 1); chk("R1 rts_n", rts_n, 0);
      chk("R1 drop", rx_drop, 0); chk("R1 xoff_evt", xoff_evt, 0); chk("R1 spec_evt", spec_evt, 0);
      edges(1);

      // R4 idle tracking
      cfg_cts_en = 1; cts_n = 1;
      edges(SY + 1); #1 chk("R4 blocked after latency", tx_permit, 0);
      cts_n = 0;
      edges(SY);     #1 chk("R4 not yet", tx_permit, 0);
      edges(1);      #1 chk("R4 clear", tx_permit, 1);
      cts_n = 1; edges(SY + 2);
      // R2 disable
      cfg_cts_en = 0; #1 chk("R2 disabled ignores cts", tx_permit, 1);
      edges(2); #1 chk("R2 still permitted", tx_permit, 1);
      cfg_cts_en = 1; #1 chk("R4 re-enable blocked", tx_permit, 0);
      // R3 busy: cts change seen only at stop-bit strobe
      tx_busy = 1; cts_n = 0;
      edges(SY + 3); #1 chk("R3 no change mid byte", tx_permit, 0);
      tx_stop_mid = 1; edges(1); tx_stop_mid = 0;
      #1 chk("R3 decided at stop mid", tx_permit, 1);
      cts_n = 1; edges(SY + 3); #1 chk("R3 holds permit mid byte", tx_permit, 1);
      tx_stop_mid = 1; edges(1); tx_stop_mid = 0;
      #1 chk("R3 blocks next byte", tx_permit, 0);
      tx_busy = 0; cts_n = 0; edges(SY + 2);
      cfg_cts_en = 0;

      // R5/R6 RTS ramps over several threshold pairs
      cfg_rts_en = 1;
      for (int p = 0; p < 4; p++) begin
         cfg_halt_lvl = LW'(pairs_h[p]); cfg_resume_lvl = LW'(pairs_r[p]);
         rx_level = '0; edges(1); halt_m = 1'b0;
         for (int s = 0; s < 2 * (1 << LW); s++) begin
            lv = (s < (1 << LW)) ? s : (2 * (1 << LW) - 1 - s);
            rx_level = LW'(lv);
            if (lv >= pairs_h[p]) halt_m = 1'b1;
            else if (lv <= pairs_r[p]) halt_m = 1'b0;
            edges(1);
            #1 chk(halt_m ? "R5 rts halt" : "R6 rts resume", rts_n, halt_m);
         end
      end
      // R7 disable
      rx_level = LW'(127); cfg_halt_lvl = LW'(4); edges(1);
      #1 chk("R5 halted before disable", rts_n, 1);
      cfg_rts_en = 0; edges(1); #1 chk("R7 disabled active", rts_n, 0);
      rx_level = '0;

      // R8/R9 exhaustive sweeps for both single-word sets
      for (int m = 1; m <= 2; m++) begin
         cfg_sw_mode = 2'd0; edges(1);
         cfg_sw_mode = 2'(m); hold_m = 1'b0;
         xon_w  = (m == 1) ? cfg_xon1  : cfg_xon2;
         xoff_w = (m == 1) ? cfg_xoff1 : cfg_xoff2;
         for (int c = 0; c < 256; c++) begin
            logic is_off, is_on;
            is_off = (8'(c) == xoff_w);
            is_on  = (8'(c) == xon_w);
            if (is_off) hold_m = 1'b1; else if (is_on) hold_m = 1'b0;
            send(8'(c), is_off ? "R8 xoff" : (is_on ? "R9 xon" : "R9 data"),
                 is_off | is_on, is_off, 1'b0, !hold_m);
         end
      end
      // R8 equal words: Xoff wins
      cfg_sw_mode = 2'd1; cfg_xon1 = 8'h13;
      send(8'h13, "R8 equal words", 1, 1, 0, 0);
      cfg_xon1 = 8'h11;
      send(8'h11, "R9 resume", 1, 0, 0, 1);
      // R13 mode off clears pause
      send(8'h13, "R13 pause", 1, 1, 0, 0);
      cfg_sw_mode = 2'd0; edges(1); #1 chk("R13 off clears pause", tx_permit, 1);
      send(8'h13, "R13 off no drop", 0, 0, 0, 1);

      // R10 sequence mode
      cfg_sw_mode = 2'd3;
      send(8'h13, "R10 xoff1 armed", 1, 0, 0, 1);
      send(8'h93, "R10 xoff complete", 1, 1, 0, 0);
      send(8'h41, "R10 data while paused", 0, 0, 0, 0);
      send(8'h11, "R10 xon1 armed", 1, 0, 0, 0);
      send(8'h42, "R10 break sequence", 0, 0, 0, 0);
      send(8'h91, "R10 lone xon2 is data", 0, 0, 0, 0);
      send(8'h11, "R10 xon1 again", 1, 0, 0, 0);
      send(8'h91, "R10 xon complete", 1, 0, 0, 1);
      // R11 Xon-Any: xon1 resumes as data, xon2 then stored
      cfg_xon_any = 1;
      send(8'h13, "R11 xoff1", 1, 0, 0, 1);
      send(8'h93, "R11 xoff2", 1, 1, 0, 0);
      send(8'h11, "R11 xon1 as any", 0, 0, 0, 1);
      send(8'h91, "R11 xon2 as data", 0, 0, 0, 1);
      send(8'h13, "R11 xoff1 again", 1, 0, 0, 1);
      send(8'h93, "R11 xoff2 again", 1, 1, 0, 0);
      send(8'h55, "R11 any char resumes", 0, 0, 0, 1);
      cfg_xon_any = 0;

      // R12 special character sweep in mode 0
      cfg_sw_mode = 2'd0; cfg_spec_en = 1; edges(1);
      for (int c = 0; c < 256; c++)
         send(8'(c), "R12 special", 0, 0, 8'(c) == cfg_xoff2, 1);
      cfg_spec_en = 0;
      send(8'h93, "R12 disabled", 0, 0, 0, 1);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule